// File: doc/BRIEF.md
# Lockable cache way replacement selector

This block picks the destination way for a line fill in a four-way set-associative cache. Each cycle the cache controller may present one lookup result: the set index, whether the access was a prefetch, whether it hit, and on a hit, which way. On a miss the block raises a one-cycle fill strobe together with the chosen way, one clock after the lookup. It keeps its own least-recently-used order for every set and updates it on ordinary hits and on every fill.

A lock mode, entered by a status bit driven from outside, lets software reserve ways 2 and 3. A small control register holds a lock flag and a load flag for each of these two ways. In lock mode a prefetch miss can be steered into a reserved way, and ordinary misses never evict a locked way. When the status bit is low, the register contents have no effect and every miss follows plain LRU.

The lookup input carries control information and not a data stream. It has no ready signal. The block accepts one lookup per cycle and never applies back-pressure. The fill strobe is also a plain pulse, and the refill engine downstream must take it in the cycle it appears.

Top module: `way_lock_sel`

## Requirements
- R1: While reset is held and on the first cycle after it, `fill_en` is 0 and `cfg_rdata` reads 0. Every set's LRU order starts with way 0 oldest, then 1, 2, and 3 newest.
- R2: A write stores bit 9 (way-3 load), bit 8 (way-3 lock), bit 1 (way-2 load) and bit 0 (way-2 lock). The new value is visible on `cfg_rdata` from the next cycle. All other bits always read 0.
- R3: A lookup with `acc_valid`=1 and `acc_hit`=0 raises `fill_en` for exactly the next cycle, with `fill_way` set. A hit never raises `fill_en`.
- R4: Outside lock mode, the fill goes to the least recently used way of the set. An ordinary hit makes the hit way the most recent, and so does a fill.
- R5: A prefetch hit changes neither the fill output nor the LRU order.
- R6: With `lock_mode`=0, the register contents do not affect the selection for prefetch or for ordinary misses.
- R7: A prefetch miss in lock mode with way-3 load and way-3 lock both 1 fills way 3. This holds even when way 2 also qualifies.
- R8: A prefetch miss in lock mode with way-2 load and lock both 1, and way 3 not qualifying, fills way 2.
- R9: Any other prefetch miss in lock mode fills the LRU way among all four ways, locked ways included.
- R10: An ordinary miss in lock mode never selects a way whose lock bit is 1. It fills the least recently used of the unlocked ways. The load bits are ignored for ordinary misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A lookup result is present this cycle |
| acc_prefetch | input | 1 | The lookup came from a prefetch |
| acc_hit | input | 1 | The lookup hit |
| acc_hit_way | input | 2 | Way that hit, meaningful when `acc_hit`=1 |
| acc_set | input | $clog2(NUM_SETS) | Set index of the lookup |
| lock_mode | input | 1 | Status bit that enables lock mode |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data |
| cfg_rdata | output | CFG_W | Control register read value |
| fill_en | output | 1 | One-cycle fill request |
| fill_way | output | 2 | Way to fill, valid with `fill_en` |

## Verification
The assertions assume the lookup fields are stable inside the cycle in which `acc_valid` is high. They also assume `acc_hit_way` is only meaningful when `acc_hit` is set. The block does not cross-check a hit against its own fill history, so the stimulus presents hit ways freely and keeps every other field at a defined level. Each register write sits in its own cycle ahead of the lookup that depends on it, so the selection always uses settled lock bits. Sets are chosen so that each case starts from a known LRU order.

// File: rtl/waylock_pkg.sv
package waylock_pkg;

  localparam int WAYS  = 4;
  localparam int PAIRS = WAYS * (WAYS - 1) / 2;

  // control register bit positions
  localparam int B_W2_LOCK = 0;
  localparam int B_W2_LOAD = 1;
  localparam int B_W3_LOCK = 8;
  localparam int B_W3_LOAD = 9;

  typedef logic [1:0]       way_t;
  typedef logic [PAIRS-1:0] lru_t;
  typedef logic [WAYS-1:0]  wmask_t;

  typedef struct packed {
    logic w3_load;
    logic w3_lock;
    logic w2_load;
    logic w2_lock;
  } lockcfg_t;

  // index of the order bit for the pair (a,b), a < b
  function automatic logic [2:0] pair_bit(int a, int b);
    case (a)
      0:       pair_bit = 3'(b - 1);
      1:       pair_bit = 3'(b + 1);
      default: pair_bit = 3'd5;
    endcase
  endfunction

  // order bit = 1 when the lower way of the pair was used more recently
  function automatic logic is_older(lru_t m, int i, int j);
    if (i < j) is_older = !m[pair_bit(i, j)];
    else       is_older =  m[pair_bit(j, i)];
  endfunction

  function automatic lru_t lru_touch(lru_t m, way_t w);
    lru_t r;
    r = m;
    for (int i = 0; i < WAYS; i++) begin
      for (int j = i + 1; j < WAYS; j++) begin
        if (way_t'(i) == w) r[pair_bit(i, j)] = 1'b1;
        if (way_t'(j) == w) r[pair_bit(i, j)] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic way_t lru_oldest(lru_t m, wmask_t cand);
    way_t res;
    logic found;
    logic ok;
    res   = '0;
    found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      ok = cand[i];
      for (int j = 0; j < WAYS; j++) begin
        if (j != i && cand[j] && !is_older(m, i, j)) ok = 1'b0;
      end
      if (ok && !found) begin
        res   = way_t'(i);
        found = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/waylock_cfg.sv
module waylock_cfg
  import waylock_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output lockcfg_t         cfg
);

  lockcfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.w3_load <= wdata[B_W3_LOAD];
      cfg_q.w3_lock <= wdata[B_W3_LOCK];
      cfg_q.w2_load <= wdata[B_W2_LOAD];
      cfg_q.w2_lock <= wdata[B_W2_LOCK];
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[B_W3_LOAD] = cfg_q.w3_load;
    rdata[B_W3_LOCK] = cfg_q.w3_lock;
    rdata[B_W2_LOAD] = cfg_q.w2_load;
    rdata[B_W2_LOCK] = cfg_q.w2_lock;
  end

  assign cfg = cfg_q;

  // reserved write bits are dropped on purpose
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CFG_W-1:B_W3_LOAD+1], wdata[B_W3_LOCK-1:B_W2_LOAD+1]};

endmodule

// File: rtl/waylock_lru.sv
module waylock_lru
  import waylock_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output lru_t             rd_order,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  way_t             upd_way
);

  lru_t order_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        order_q[s] <= '0;
      end else if (upd_en && upd_set == SET_W'(s)) begin
        order_q[s] <= lru_touch(order_q[s], upd_way);
      end
    end
  end

  assign rd_order = order_q[rd_set];

endmodule

// File: rtl/waylock_pick.sv
module waylock_pick
  import waylock_pkg::*;
(
  input  logic     lock_mode,
  input  logic     prefetch,
  input  lockcfg_t cfg,
  input  lru_t     order,
  output way_t     victim
);

  logic   pf_w3, pf_w2;
  wmask_t cand;

  always_comb begin
    pf_w3 = lock_mode && prefetch && cfg.w3_load && cfg.w3_lock;
    pf_w2 = lock_mode && prefetch && cfg.w2_load && cfg.w2_lock;
    cand  = '1;
    if (lock_mode && !prefetch) begin
      cand[3] = !cfg.w3_lock;
      cand[2] = !cfg.w2_lock;
    end
    if (pf_w3)      victim = way_t'(3);
    else if (pf_w2) victim = way_t'(2);
    else            victim = lru_oldest(order, cand);
  end

endmodule

// File: rtl/way_lock_sel.sv
module way_lock_sel
  import waylock_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int CFG_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic                        acc_prefetch,
  input  logic                        acc_hit,
  input  logic [1:0]                  acc_hit_way,
  input  logic [$clog2(NUM_SETS)-1:0] acc_set,
  input  logic                        lock_mode,
  input  logic                        cfg_we,
  input  logic [CFG_W-1:0]            cfg_wdata,
  output logic [CFG_W-1:0]            cfg_rdata,
  output logic                        fill_en,
  output logic [1:0]                  fill_way
);

  localparam int SET_W = $clog2(NUM_SETS);

  lockcfg_t cfg;
  lru_t     order;
  way_t     victim;
  logic     miss, upd_en;
  way_t     upd_way;

  waylock_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  waylock_lru #(.NUM_SETS(NUM_SETS)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (acc_set),
    .rd_order (order),
    .upd_en   (upd_en),
    .upd_set  (acc_set),
    .upd_way  (upd_way)
  );

  waylock_pick u_pick (
    .lock_mode (lock_mode),
    .prefetch  (acc_prefetch),
    .cfg       (cfg),
    .order     (order),
    .victim    (victim)
  );

  assign miss    = acc_valid && !acc_hit;
  assign upd_en  = miss || (acc_valid && acc_hit && !acc_prefetch);
  assign upd_way = miss ? victim : acc_hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_en  <= 1'b0;
      fill_way <= '0;
    end else begin
      fill_en <= miss;
      if (miss) fill_way <= victim;
    end
  end

endmodule

// File: rtl/waylock_chk.sv
module waylock_chk #(
  parameter int NUM_SETS = 16,
  parameter int CFG_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_valid,
  input logic                        acc_prefetch,
  input logic                        acc_hit,
  input logic [$clog2(NUM_SETS)-1:0] acc_set,
  input logic                        lock_mode,
  input logic                        cfg_we,
  input logic [CFG_W-1:0]            cfg_wdata,
  input logic [CFG_W-1:0]            cfg_rdata,
  input logic                        fill_en,
  input logic [1:0]                  fill_way
);

  localparam logic [CFG_W-1:0] KEEP = CFG_W'(32'h0000_0303);

  logic unused_set;
  assign unused_set = ^acc_set;

  AST_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_hit |=> fill_en); // R3

  AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_hit) |=> !fill_en); // R3

  AST_PF_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_hit && acc_prefetch |=> !fill_en); // R5

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & KEEP)); // R2

  AST_PF_TO_W3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_hit && acc_prefetch && lock_mode && cfg_rdata[9] && cfg_rdata[8]
    |=> fill_way == 2'd3); // R7

  AST_W3_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_hit && !acc_prefetch && lock_mode && cfg_rdata[8]
    |=> fill_way != 2'd3); // R10

  AST_W2_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_hit && !acc_prefetch && lock_mode && cfg_rdata[0]
    |=> fill_way != 2'd2); // R10

endmodule

bind way_lock_sel waylock_chk #(.NUM_SETS(NUM_SETS), .CFG_W(CFG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid    (acc_valid),
  .acc_prefetch (acc_prefetch),
  .acc_hit      (acc_hit),
  .acc_set      (acc_set),
  .lock_mode    (lock_mode),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .fill_en      (fill_en),
  .fill_way     (fill_way)
);

// File: tb/way_lock_sel_bench.sv
`timescale 1ns/1ps
module way_lock_sel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_prefetch = 1'b0, acc_hit = 1'b0;
  logic [1:0]  acc_hit_way = '0;
  logic [3:0]  acc_set = '0;
  logic        lock_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fill_en;
  logic [1:0]  fill_way;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  way_lock_sel u_way_lock_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_prefetch(acc_prefetch),
    .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_set(acc_set),
    .lock_mode(lock_mode), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fill_en(fill_en), .fill_way(fill_way)
  );

  // cfg nibble = {w3 load (bit 9), w3 lock (bit 8), w2 load (bit 1), w2 lock (bit 0)}
  typedef struct packed {
    logic [3:0] cfg;
    logic       lk;
    logic       pf;
    logic       hit;
    logic [1:0] hw;
    logic [3:0] set;
    logic       ef;
    logic [1:0] ew;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{4'b0000,1'b0,1'b0,1'b0,2'd0,4'd0,1'b1,2'd0,4'd4},   // R4 fresh set: way 0
    '{4'b0000,1'b0,1'b0,1'b0,2'd0,4'd0,1'b1,2'd1,4'd4},   // R4 next oldest
    '{4'b0000,1'b0,1'b0,1'b1,2'd2,4'd0,1'b0,2'd0,4'd3},   // R3 hit, no fill
    '{4'b0000,1'b0,1'b0,1'b0,2'd0,4'd0,1'b1,2'd3,4'd4},   // R4 hit moved way 2 up
    '{4'b1111,1'b0,1'b1,1'b0,2'd0,4'd1,1'b1,2'd0,4'd6},   // R6 prefetch, lock off
    '{4'b1111,1'b0,1'b0,1'b0,2'd0,4'd1,1'b1,2'd1,4'd6},   // R6 ordinary, lock off
    '{4'b1100,1'b1,1'b1,1'b0,2'd0,4'd2,1'b1,2'd3,4'd7},   // R7
    '{4'b1111,1'b1,1'b1,1'b0,2'd0,4'd2,1'b1,2'd3,4'd7},   // R7 priority over way 2
    '{4'b0011,1'b1,1'b1,1'b0,2'd0,4'd3,1'b1,2'd2,4'd8},   // R8
    '{4'b1011,1'b1,1'b1,1'b0,2'd0,4'd4,1'b1,2'd2,4'd8},   // R8 way 3 lacks lock
    '{4'b1000,1'b1,1'b1,1'b0,2'd0,4'd5,1'b1,2'd0,4'd9},   // R9
    '{4'b0100,1'b1,1'b1,1'b0,2'd0,4'd6,1'b1,2'd0,4'd9},   // R9
    '{4'b0000,1'b1,1'b1,1'b1,2'd0,4'd7,1'b0,2'd0,4'd5},   // R5 prefetch hit way 0
    '{4'b0000,1'b0,1'b0,1'b0,2'd0,4'd7,1'b1,2'd0,4'd5},   // R5 way 0 still oldest
    '{4'b0000,1'b0,1'b0,1'b1,2'd0,4'd8,1'b0,2'd0,4'd4},   // R4 hit
    '{4'b0000,1'b0,1'b0,1'b1,2'd1,4'd8,1'b0,2'd0,4'd4},   // R4 hit
    '{4'b0101,1'b1,1'b0,1'b0,2'd0,4'd8,1'b1,2'd0,4'd10},  // R10 ways 2,3 locked
    '{4'b0101,1'b1,1'b0,1'b0,2'd0,4'd8,1'b1,2'd1,4'd10},  // R10
    '{4'b0000,1'b0,1'b0,1'b1,2'd0,4'd9,1'b0,2'd0,4'd4},   // R4 hit
    '{4'b0000,1'b0,1'b0,1'b1,2'd1,4'd9,1'b0,2'd0,4'd4},   // R4 hit
    '{4'b0000,1'b0,1'b0,1'b1,2'd2,4'd9,1'b0,2'd0,4'd4},   // R4 hit
    '{4'b1100,1'b1,1'b0,1'b0,2'd0,4'd9,1'b1,2'd0,4'd10},  // R10 load bit ignored
    '{4'b0011,1'b1,1'b0,1'b0,2'd0,4'd9,1'b1,2'd3,4'd10}   // R10 only way 2 locked
  };

  function automatic logic [31:0] cfg_word(logic [3:0] c);
    logic [31:0] w;
    w = '0;
    w[9] = c[3]; w[8] = c[2]; w[1] = c[1]; w[0] = c[0];
    return w;
  endfunction

  task automatic check(input logic ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = cfg_word(v.cfg);
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = 1'b1; acc_prefetch = v.pf; acc_hit = v.hit;
    acc_hit_way = v.hw; acc_set = v.set; lock_mode = v.lk;
    @(negedge clk);
    acc_valid = 1'b0;
    check(fill_en == v.ef, int'(v.req), "fill_en", 32'(fill_en), 32'(v.ef));
    if (v.ef) check(fill_way == v.ew, int'(v.req), "fill_way", 32'(fill_way), 32'(v.ew));
    @(negedge clk);
    check(fill_en == 1'b0, 3, "pulse width", 32'(fill_en), 0);   // R3
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 during reset
    repeat (3) @(negedge clk);
    check(fill_en == 1'b0, 1, "fill_en in reset", 32'(fill_en), 0);
    check(cfg_rdata == 32'h0, 1, "cfg in reset", cfg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fill_en == 1'b0, 1, "fill_en after reset", 32'(fill_en), 0);   // R1
    check(cfg_rdata == 32'h0, 1, "cfg after reset", cfg_rdata, 0);

    // R2 reserved bits
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == 32'h0000_0303, 2, "all-ones write", cfg_rdata, 32'h303);
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FCFC;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == 32'h0, 2, "reserved-only write", cfg_rdata, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R3 and R4: back-to-back misses on a fresh set (R1 order 0,1,2,3)
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = 1'b1; acc_prefetch = 1'b0; acc_hit = 1'b0; acc_set = 4'd10; lock_mode = 1'b0;
    @(negedge clk);
    check(fill_en && fill_way == 2'd0, 4, "b2b first", 32'(fill_way), 0);
    @(negedge clk);
    acc_valid = 1'b0;
    check(fill_en && fill_way == 2'd1, 4, "b2b second", 32'(fill_way), 1);
    @(negedge clk);
    check(!fill_en, 3, "b2b end", 32'(fill_en), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule